// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is the slave side of a byte-wide serial EEPROM reached over a four-wire SPI link in mode 0. A host lowers chip select, shifts in one instruction byte (most significant bit first) and, depending on the command, a two-byte address and data bytes, or clocks out status or array bytes. The block decodes six commands: enable writes, disable writes, read status, write status, read array and write array. The array is a parameterized bank of byte registers inside the block.

All four serial pins are sampled by the block's own clock through a synchronizer, so the serial clock must run several times slower than `clk`. A write to the array or to the status register is held until chip select returns high on a byte boundary. Committing it starts an emulated internal write cycle whose length is a count of `clk` cycles. During that cycle the status byte reads as all ones and only the status read is honoured. The serial link has no back-pressure: the host paces every bit, and the block neither stalls nor buffers beyond one staged byte. For that reason no valid/ready handshake appears at its edge.

Top module: `spi_eeprom`

## Requirements
- R1: An instruction byte is obeyed only when bits 7..4 are 0000. Bit 3 is a don't-care. Bits 2..0 select the command: 110 enable writes, 100 disable writes, 101 read status, 001 write status, 011 read array, 010 write array. Any other byte makes the block ignore the rest of that select.
- R2: Every byte moves most significant bit first. SI is taken on the rising edge of SCK and SO changes on the falling edge. The first bit of an output byte is on SO before the first rising SCK edge of that byte.
- R3: After reset the write-enable flag is 0. A write-status or write-array command issued while the flag is 0 has no effect.
- R4: The disable-writes command clears the write-enable flag at either level of `wp_n`.
- R5: When no write cycle is running, the status byte is {protect-enable (bit 7), 000, block-protect bits (bits 3..2), write-enable flag (bit 1), 0 (bit 0)}. The read-status command keeps returning that byte for as long as chip select stays low.
- R6: While a write cycle is running, the status byte reads 8'hFF.
- R7: Read array takes a 16-bit address, of which only the low log2(DEPTH) bits are used. It then returns bytes for as long as chip select stays low, incrementing the address and wrapping from DEPTH-1 to 0.
- R8: Write array stores the last complete data byte of the select at the given address. This happens only when chip select rises with no partial byte pending; otherwise nothing is stored and no write cycle starts.
- R9: A committed write lasts BUSY_CYCLES `clk` cycles. The write-enable flag clears when it ends.
- R10: While a write cycle is running, every instruction except read status is ignored.
- R11: Write status changes only bits 7, 3 and 2. It is refused when the stored protect-enable bit is 1 and `wp_n` is low.
- R12: `so_en` is high exactly while the synchronized chip select is low, which is SYNC_STAGES `clk` cycles after the pin. `so` is 0 whenever `so_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host, idle low |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out of the block |
| so_en | output | 1 | High when `so` should drive the shared line |

## Verification
The bench builds the block with DEPTH=16, so a 16-bit address whose high bits are set lands on a real word and a streamed read crosses the wrap point after one byte. BUSY_CYCLES is set to 800. At the bench's serial rate that spans several complete selects, so a status read, an ignored enable and an ignored array read can all fall inside one write cycle. Enough cycles are left afterwards to see the write-enable flag clear when the cycle ends. SYNC_STAGES keeps its default of 2, and `so_en` is compared against the chip-select history on every clock.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [2:0] OP_WRSR  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_READ  = 3'b011;
  localparam logic [2:0] OP_WRDI  = 3'b100;
  localparam logic [2:0] OP_RDSR  = 3'b101;
  localparam logic [2:0] OP_WREN  = 3'b110;

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_RDAT, PH_WDAT, PH_WSR, PH_RSR, PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int N_BITS = 4,
  parameter int STAGES = 2,
  parameter logic [N_BITS-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] din,
  output logic [N_BITS-1:0] dout
);
  for (genvar b = 0; b < N_BITS; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{INIT[b]}};
      else        pipe <= {pipe[STAGES-2:0], din[b]};
    end
    assign dout[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[w] <= 8'h00;
      else if (we && waddr == ADDR_W'(w))        mem[w] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import spi_ee_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  localparam int ADDR_W = $clog2(DEPTH);

  // pin synchronizer: {cs_n, sck, si, wp_n}
  logic cs_s, sck_s, si_s, wp_s;
  spi_ee_sync #(.N_BITS(4), .STAGES(SYNC_STAGES), .INIT(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({cs_n, sck, si, wp_n}),
    .dout({cs_s, sck_s, si_s, wp_s})
  );

  logic cs_p, sck_p;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cs_p <= 1'b1; sck_p <= 1'b0; end
    else        begin cs_p <= cs_s; sck_p <= sck_s; end
  end

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = cs_p & ~cs_s;
  assign cs_rise  = ~cs_p & cs_s;
  assign sck_rise = ~cs_s & ~sck_p & sck_s;
  assign sck_fall = ~cs_s & sck_p & ~sck_s;

  phase_e            phase;
  logic [2:0]        bit_cnt;
  logic [6:0]        in_sr;
  logic [7:0]        out_sr;
  logic              skip_fall;
  logic              rd_mode;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata_q;
  logic              have_data;
  logic              wel, wpen;
  logic [1:0]        bp;
  logic              busy, busy_done;

  logic [7:0] byte_in;
  logic       byte_done;
  assign byte_in   = {in_sr, si_s};
  assign byte_done = sck_rise && (bit_cnt == 3'd7);

  // address formed from the two address bytes, low ADDR_W bits only
  logic [ADDR_W-1:0] ld_addr;
  if (ADDR_W > 8) begin : g_wide
    logic [ADDR_W-9:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hi_q <= '0;
      else if (byte_done && phase == PH_AHI)   hi_q <= byte_in[ADDR_W-9:0];
    end
    assign ld_addr = {hi_q, byte_in};
  end else begin : g_narrow
    assign ld_addr = byte_in[ADDR_W-1:0];
  end

  logic [7:0] status_val;
  assign status_val = busy ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};

  logic on_boundary, commit_wr, commit_sr;
  assign on_boundary = cs_rise && (bit_cnt == 3'd0) && have_data;
  assign commit_wr   = on_boundary && (phase == PH_WDAT);
  assign commit_sr   = on_boundary && (phase == PH_WSR) && !(wpen && !wp_s);

  logic [ADDR_W-1:0] raddr;
  logic [7:0]        rdata;
  assign raddr = (phase == PH_ALO) ? ld_addr : addr;

  spi_ee_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(commit_wr), .waddr(addr), .wdata(wdata_q),
    .raddr(raddr), .rdata(rdata)
  );

  spi_ee_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .start(commit_wr || commit_sr),
    .busy(busy), .done(busy_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SKIP; bit_cnt <= '0; in_sr <= '0; out_sr <= '0;
      skip_fall <= 1'b0; rd_mode <= 1'b0; addr <= '0; wdata_q <= '0;
      have_data <= 1'b0; wel <= 1'b0; wpen <= 1'b0; bp <= '0;
    end else begin
      if (busy_done) wel <= 1'b0;
      if (cs_fall) begin
        phase <= PH_CMD; bit_cnt <= '0; out_sr <= '0;
        skip_fall <= 1'b0; have_data <= 1'b0;
      end else if (cs_rise) begin
        phase <= PH_SKIP;
        if (commit_sr) begin wpen <= wdata_q[7]; bp <= wdata_q[3:2]; end
      end else begin
        if (sck_rise) begin
          in_sr   <= byte_in[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (sck_fall) begin
          if (skip_fall) skip_fall <= 1'b0;
          else           out_sr <= {out_sr[6:0], 1'b0};
        end
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              if (byte_in[7:4] != 4'b0000 || (busy && byte_in[2:0] != OP_RDSR)) begin
                phase <= PH_SKIP;
              end else begin
                case (byte_in[2:0])
                  OP_WREN:  begin wel <= 1'b1; phase <= PH_SKIP; end
                  OP_WRDI:  begin wel <= 1'b0; phase <= PH_SKIP; end
                  OP_RDSR:  begin phase <= PH_RSR; out_sr <= status_val; skip_fall <= 1'b1; end
                  OP_WRSR:  phase <= wel ? PH_WSR : PH_SKIP;
                  OP_READ:  begin rd_mode <= 1'b1; phase <= PH_AHI; end
                  OP_WRITE: begin rd_mode <= 1'b0; phase <= wel ? PH_AHI : PH_SKIP; end
                  default:  phase <= PH_SKIP;
                endcase
              end
            end
            PH_AHI: phase <= PH_ALO;
            PH_ALO: begin
              if (rd_mode) begin
                phase <= PH_RDAT; out_sr <= rdata;
                addr <= ld_addr + 1'b1; skip_fall <= 1'b1;
              end else begin
                phase <= PH_WDAT; addr <= ld_addr;
              end
            end
            PH_RDAT: begin out_sr <= rdata; addr <= addr + 1'b1; skip_fall <= 1'b1; end
            PH_RSR:  begin out_sr <= status_val; skip_fall <= 1'b1; end
            PH_WDAT, PH_WSR: begin wdata_q <= byte_in; have_data <= 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end

  assign so_en = ~cs_s;
  assign so    = so_en & out_sr[7];
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       so,
  input logic       so_en,
  input logic       busy,
  input logic       wel,
  input logic       wpen,
  input logic [1:0] bp
);
  // R12: line quiet while not selected
  assert_so_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !so_en |-> !so);

  // R9: end of write cycle leaves writes disabled
  assert_wel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R3: a write cycle only starts from an enabled state
  assert_busy_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R10: enabling is refused during a write cycle
  assert_no_enable_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));

  // R11: protection bits frozen while the write cycle runs
  assert_prot_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({wpen, bp}));
endmodule

bind spi_eeprom spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_en(so_en),
  .busy(busy), .wel(wel), .wpen(wpen), .bp(bp)
);

// File: tb/test_spi_eeprom.sv
`timescale 1ns/1ps
module test_spi_eeprom;
  localparam int DEPTH = 16;
  localparam int BUSY  = 800;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_en;

  always #2 clk = ~clk;

  spi_eeprom #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) i_spi_eeprom (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .so_en(so_en)
  );

  int total = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  logic [7:0] m_mem [DEPTH];
  logic       m_wel = 1'b0, m_wpen = 1'b0;
  logic [1:0] m_bp = 2'b00;
  int         m_busy_end = 0;

  function automatic logic [7:0] m_status(int at);
    if (at < m_busy_end) return 8'hFF;
    return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // per-clock reference: so_en follows cs_n two clocks late, so quiet (R12)
  logic h1 = 1'b1, h2 = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (so_en !== ~h2 || (!so_en && so !== 1'b0)) begin
        fails++;
        $display("FAIL R12 per-clock: actual so_en=%0b so=%0b expected so_en=%0b", so_en, so, ~h2);
      end
    end
    h2 = h1; h1 = cs_n;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  int end_cyc, start_cyc;

  task automatic send(int tail_bits);
    logic [7:0] rx;
    rx_q.delete();
    cs_n = 1'b0; start_cyc = cyc; tick(HALF);
    foreach (tx_q[k]) begin
      for (int i = 7; i >= 0; i--) begin
        si = tx_q[k][i]; tick(HALF); rx[i] = so;
        sck = 1'b1; tick(HALF); sck = 1'b0;
      end
      rx_q.push_back(rx);
    end
    for (int i = 0; i < tail_bits; i++) begin
      si = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    tick(HALF); cs_n = 1'b1; end_cyc = cyc; tick(2 * HALF);
  endtask

  task automatic op1(logic [7:0] b);
    tx_q = {b}; send(0);
  endtask

  task automatic rdsr(string req, string what);
    logic [7:0] exp;
    exp = m_status(cyc + 120);
    tx_q = {8'h05, 8'h00, 8'h00}; send(0);
    chk(req, what, rx_q[1], exp);
  endtask

  task automatic wren();  op1(8'h06); if (cyc >= m_busy_end) m_wel = 1'b1; endtask
  task automatic wrdi();  op1(8'h04); if (cyc >= m_busy_end) m_wel = 1'b0; endtask

  task automatic wr_byte(logic [15:0] a, logic [7:0] d);
    tx_q = {8'h02, a[15:8], a[7:0], d}; send(0);
    if (m_wel) begin
      m_mem[a[3:0]] = d; m_wel = 1'b0; m_busy_end = end_cyc + BUSY + 4;
    end
  endtask

  task automatic wait_ready();
    tick(BUSY + 100);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R12", "so_en at reset", {7'b0, so_en}, 8'h00);
    rdsr("R3", "status after reset");

    // write without enable is dropped
    wr_byte(16'h0005, 8'h99);
    tx_q = {8'h03, 8'h00, 8'h05, 8'h00}; send(0);
    chk("R3", "array untouched without enable", rx_q[3], 8'h00);
    rdsr("R3", "no busy without enable");

    // opcode decode incl. don't-care bit 3 and bad upper nibble
    wren(); rdsr("R1", "enable 06");
    wp_n = 1'b0; wrdi(); rdsr("R4", "disable with wp_n low");
    wp_n = 1'b1;
    op1(8'h0E); m_wel = 1'b1; rdsr("R1", "enable 0E (bit3 dont care)");
    wrdi();
    op1(8'h16); rdsr("R1", "upper nibble nonzero ignored");
    op1(8'h07); rdsr("R1", "low code 111 ignored");

    // array write: last complete byte, busy handling
    wren();
    tx_q = {8'h02, 8'h00, 8'h05, 8'h11, 8'hA5}; send(0);
    m_mem[5] = 8'hA5; m_wel = 1'b0; m_busy_end = end_cyc + BUSY + 4;
    op1(8'h06);
    tx_q = {8'h03, 8'h00, 8'h05, 8'h00}; send(0);
    chk("R10", "read ignored while busy", rx_q[3], 8'h00);
    rdsr("R6", "status all ones while busy");
    wait_ready();
    rdsr("R9", "ready and enable cleared");
    tx_q = {8'h03, 8'h00, 8'h05, 8'h00}; send(0);
    chk("R8", "last data byte stored", rx_q[3], m_mem[5]);

    // partial byte aborts the write
    wren();
    tx_q = {8'h02, 8'h00, 8'h03, 8'h77}; send(3);
    rdsr("R8", "no commit on partial byte");
    tx_q = {8'h03, 8'h00, 8'h03, 8'h00}; send(0);
    chk("R8", "partial write not stored", rx_q[3], 8'h00);
    wrdi();

    // wrap and ignored high address bits
    wren(); wr_byte(16'h0000, 8'h5A); wait_ready();
    wren(); wr_byte(16'h123F, 8'h3C); wait_ready();
    tx_q = {8'h03, 8'hAB, 8'hCF, 8'h00, 8'h00, 8'h00}; send(0);
    chk("R7", "read at top word", rx_q[3], m_mem[15]);
    chk("R7", "read wraps to word 0", rx_q[4], m_mem[0]);
    chk("R2", "stream third byte", rx_q[5], m_mem[1]);

    // status writes
    wren();
    tx_q = {8'h01, 8'hFF}; send(0);
    m_wpen = 1'b1; m_bp = 2'b11; m_wel = 1'b0; m_busy_end = end_cyc + BUSY + 4;
    wait_ready();
    rdsr("R11", "only bits 7,3,2 written");
    rdsr("R5", "status repeat read");
    wren(); wp_n = 1'b0;
    tx_q = {8'h01, 8'h00}; send(0);
    rdsr("R11", "write status refused under protect");
    wp_n = 1'b1;
    tx_q = {8'h01, 8'h00}; send(0);
    m_wpen = 1'b0; m_bp = 2'b00; m_wel = 1'b0; m_busy_end = end_cyc + BUSY + 4;
    wait_ready();
    rdsr("R11", "write status accepted with wp_n high");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++; total++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule